// File: doc/BRIEF.md
# Pipelined Bitonic Sorting Network

This block sorts a group of equal-width values that arrive side by side on one wide bus. It is built from Batcher's bitonic merge: layers of compare-exchange elements, each of which puts the two values it sees into the wanted order. A bus of LANES lanes with lg = log2(LANES) passes through lg*(lg+1)/2 comparator layers. Each layer holds LANES/2 elements, which gives LANES*lg*(lg+1)/4 elements in total.

A new vector may be presented on every clock edge. After a fixed number of cycles the same values come out in order on the output bus. Parameters choose the sort direction and whether lanes are compared as unsigned or as two's-complement numbers. A third parameter sets how often a register stage is placed between comparator layers. The range runs from a register after every layer down to no register at all. There is no reset and no valid or flow-control signalling. The output is meaningful once the pipeline has filled. LANES must be a power of two and at least 2. Any other value stops elaboration.

Top module: `bitonic_sorter`

## Requirements
- R1: With DESCEND=0 the output lanes are non-decreasing from lane 0 upward, so lane 0 holds the smallest input value.
- R2: With DESCEND=1 the output lanes are non-increasing from lane 0 upward, so lane 0 holds the largest input value.
- R3: With SIGNED_CMP=0 lanes are compared as unsigned magnitudes, so an all-ones lane is the largest value.
- R4: With SIGNED_CMP=1 lanes are compared as two's-complement numbers, so a lane whose top bit is set is negative and a lane of 1 followed by zeros is the smallest value.
- R5: Lane i occupies bits [ELEM_W*(i+1)-1 -: ELEM_W] of both sort_in and sort_out, so lane 0 is in the least significant bits.
- R6: With REG_EVERY=k>0, a register follows each comparator layer whose 1-based number is a multiple of k. The latency is therefore floor(L/k) clock cycles, where L = lg*(lg+1)/2. A registered configuration's output does not change between clock edges.
- R7: With REG_EVERY=0, or with REG_EVERY greater than L, the network has no registers and sort_out follows sort_in within the same cycle.
- R8: A new vector is accepted on every cycle, and each output vector depends only on the one input vector it came from.
- R9: The output holds exactly the input's values, duplicates included, so a vector of equal values comes out unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the pipeline registers |
| sort_in | input | LANES*ELEM_W | Packed unsorted vector, lane 0 in the low bits |
| sort_out | output | LANES*ELEM_W | Packed sorted vector, delayed by the pipeline latency |

## Verification
The bench runs three configurations: fully pipelined ascending unsigned, partly pipelined descending signed, and register-free descending unsigned. Each is driven with random data, all-equal vectors, rising and falling ramps, a mix of the signed and unsigned extremes, and vectors drawn from only three values. A comparator that used the wrong signedness would put the 1-followed-by-zeros value at the wrong end of the vector. A wrong direction flag in any merge block would leave a local inversion. Losing or doubling a value on ties would break the equal-value and three-value patterns. A misplaced register would make the output appear one cycle early or late, or change between clock edges. In the register-free configuration the bench checks the output in the same cycle the input was driven.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

    // number of comparator layers for 2**lg lanes
    function automatic int layer_count(input int lg);
        return lg * (lg + 1) / 2;
    endfunction

    // cycles of delay when a register follows every 'every'-th layer
    function automatic int stage_latency(input int layers, input int every);
        return (every <= 0) ? 0 : layers / every;
    endfunction

    function automatic bit is_pow2(input int n);
        return (n >= 2) && ((n & (n - 1)) == 0);
    endfunction

    // flat 0-based position of merge step q inside merge phase p
    function automatic int layer_index(input int p, input int q);
        return p * (p + 1) / 2 + q;
    endfunction

    // lower lane of the m-th pair when partners are 2**span_log apart
    function automatic int low_lane(input int m, input int span_log);
        return ((m >> span_log) << (span_log + 1)) | (m & ((1 << span_log) - 1));
    endfunction

endpackage

// File: rtl/bsort_cmpx.sv
module bsort_cmpx #(
    parameter int ELEM_W     = 16,
    parameter bit SIGNED_CMP = 1'b0,
    parameter bit MIN_LOW    = 1'b1
) (
    input  logic [ELEM_W-1:0] a_i,
    input  logic [ELEM_W-1:0] b_i,
    output logic [ELEM_W-1:0] lo_o,
    output logic [ELEM_W-1:0] hi_o
);

    logic a_above;
    logic b_above;
    logic swap;

    if (SIGNED_CMP) begin : g_signed
        assign a_above = $signed(a_i) > $signed(b_i);
        assign b_above = $signed(b_i) > $signed(a_i);
    end else begin : g_unsigned
        assign a_above = a_i > b_i;
        assign b_above = b_i > a_i;
    end

    // strict comparison: ties leave the pair as it is
    assign swap = MIN_LOW ? a_above : b_above;
    assign lo_o = swap ? b_i : a_i;
    assign hi_o = swap ? a_i : b_i;

endmodule

// File: rtl/bsort_layer.sv
module bsort_layer import bsort_pkg::*; #(
    parameter int LANES      = 8,
    parameter int ELEM_W     = 16,
    parameter int SPAN_LOG   = 0,
    parameter int BLOCK_LOG  = 1,
    parameter bit DESCEND    = 1'b0,
    parameter bit SIGNED_CMP = 1'b0,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                    clk,
    input  logic [LANES*ELEM_W-1:0] d_i,
    output logic [LANES*ELEM_W-1:0] d_o
);

    localparam int PAIRS = LANES / 2;
    localparam int SPAN  = 1 << SPAN_LOG;

    wire [LANES*ELEM_W-1:0] swapped;

    for (genvar m = 0; m < PAIRS; m++) begin : g_pair
        localparam int LO        = low_lane(m, SPAN_LOG);
        localparam int HI        = LO + SPAN;
        localparam bit UP_BLOCK  = ((LO >> BLOCK_LOG) & 1) == 0;
        localparam bit MIN_FIRST = UP_BLOCK ^ DESCEND;

        bsort_cmpx #(
            .ELEM_W    (ELEM_W),
            .SIGNED_CMP(SIGNED_CMP),
            .MIN_LOW   (MIN_FIRST)
        ) u_cx (
            .a_i (d_i[LO*ELEM_W +: ELEM_W]),
            .b_i (d_i[HI*ELEM_W +: ELEM_W]),
            .lo_o(swapped[LO*ELEM_W +: ELEM_W]),
            .hi_o(swapped[HI*ELEM_W +: ELEM_W])
        );
    end

    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk) begin
            d_o <= swapped;
        end
    end else begin : g_wire
        assign d_o = swapped;
    end

endmodule

// File: rtl/bitonic_sorter.sv
module bitonic_sorter import bsort_pkg::*; #(
    parameter int LANES      = 8,
    parameter int ELEM_W     = 16,
    parameter bit DESCEND    = 1'b0,
    parameter bit SIGNED_CMP = 1'b0,
    parameter int REG_EVERY  = 1
) (
    input  logic                    clk,
    input  logic [LANES*ELEM_W-1:0] sort_in,
    output logic [LANES*ELEM_W-1:0] sort_out
);

    localparam int LG      = $clog2(LANES);
    localparam int LAYERS  = layer_count(LG);
    localparam int BUS_W   = LANES * ELEM_W;
    localparam int LATENCY = stage_latency(LAYERS, REG_EVERY);

    if (!is_pow2(LANES)) begin : g_bad_lanes
        $error("bitonic_sorter: LANES must be a power of two and at least 2");
    end

    logic [BUS_W-1:0] stage_bus [0:LAYERS];

    assign stage_bus[0] = sort_in;

    // merge phase p builds sorted runs of 2**(p+1); step q compares lanes 2**(p-q) apart
    for (genvar p = 0; p < LG; p++) begin : g_phase
        for (genvar q = 0; q <= p; q++) begin : g_step
            localparam int T        = layer_index(p, q);
            localparam bit REG_HERE = (REG_EVERY > 0) && (((T + 1) % REG_EVERY) == 0);

            bsort_layer #(
                .LANES     (LANES),
                .ELEM_W    (ELEM_W),
                .SPAN_LOG  (p - q),
                .BLOCK_LOG (p + 1),
                .DESCEND   (DESCEND),
                .SIGNED_CMP(SIGNED_CMP),
                .REGISTERED(REG_HERE)
            ) u_layer (
                .clk(clk),
                .d_i(stage_bus[T]),
                .d_o(stage_bus[T+1])
            );
        end
    end

    assign sort_out = stage_bus[LAYERS];

endmodule

// File: rtl/bsort_chk.sv
module bsort_chk import bsort_pkg::*; #(
    parameter int LANES      = 8,
    parameter int ELEM_W     = 16,
    parameter bit DESCEND    = 1'b0,
    parameter bit SIGNED_CMP = 1'b0,
    parameter int REG_EVERY  = 1
) (
    input logic                    clk,
    input logic [LANES*ELEM_W-1:0] sort_in,
    input logic [LANES*ELEM_W-1:0] sort_out
);

    localparam int LG      = $clog2(LANES);
    localparam int LAYERS  = layer_count(LG);
    localparam int BUS_W   = LANES * ELEM_W;
    localparam int LATENCY = stage_latency(LAYERS, REG_EVERY);
    localparam int SUM_W   = ELEM_W + LG + 1;

    int warm = 0;
    always_ff @(posedge clk) begin
        if (warm <= LATENCY) warm <= warm + 1;
    end

    logic [BUS_W-1:0] past_in;

    if (LATENCY == 0) begin : g_nodelay
        assign past_in = sort_in;
    end else begin : g_delay
        logic [BUS_W-1:0] pipe_q [LATENCY];
        always_ff @(posedge clk) begin
            pipe_q[0] <= sort_in;
            for (int k = 1; k < LATENCY; k++) pipe_q[k] <= pipe_q[k-1];
        end
        assign past_in = pipe_q[LATENCY-1];
    end

    // x must precede y in the output order
    function automatic logic goes_before(input logic [ELEM_W-1:0] x, input logic [ELEM_W-1:0] y);
        if (SIGNED_CMP) return DESCEND ? ($signed(x) > $signed(y)) : ($signed(x) < $signed(y));
        return DESCEND ? (x > y) : (x < y);
    endfunction

    logic              order_ok;
    logic [SUM_W-1:0]  sum_in, sum_out;
    logic [ELEM_W-1:0] xor_in, xor_out, first_ref, last_ref;

    always_comb begin
        order_ok  = 1'b1;
        sum_in    = '0;
        sum_out   = '0;
        xor_in    = '0;
        xor_out   = '0;
        first_ref = past_in[ELEM_W-1:0];
        last_ref  = past_in[ELEM_W-1:0];
        for (int i = 0; i < LANES; i++) begin
            sum_in  = sum_in + SUM_W'(past_in[i*ELEM_W +: ELEM_W]);
            sum_out = sum_out + SUM_W'(sort_out[i*ELEM_W +: ELEM_W]);
            xor_in  = xor_in ^ past_in[i*ELEM_W +: ELEM_W];
            xor_out = xor_out ^ sort_out[i*ELEM_W +: ELEM_W];
            if (goes_before(past_in[i*ELEM_W +: ELEM_W], first_ref)) first_ref = past_in[i*ELEM_W +: ELEM_W];
            if (goes_before(last_ref, past_in[i*ELEM_W +: ELEM_W])) last_ref = past_in[i*ELEM_W +: ELEM_W];
            if (i > 0 && goes_before(sort_out[i*ELEM_W +: ELEM_W], sort_out[(i-1)*ELEM_W +: ELEM_W]))
                order_ok = 1'b0;
        end
    end

    // R1 R2
    out_ordered_chk: assert property (@(posedge clk) disable iff (warm <= LATENCY) order_ok);

    // R9
    sum_kept_chk: assert property (@(posedge clk) disable iff (warm <= LATENCY) sum_out == sum_in);

    // R9
    xor_kept_chk: assert property (@(posedge clk) disable iff (warm <= LATENCY) xor_out == xor_in);

    // R1 R2 R6
    lane0_extreme_chk: assert property (@(posedge clk) disable iff (warm <= LATENCY)
        sort_out[ELEM_W-1:0] == first_ref);

    // R1 R2 R6
    top_extreme_chk: assert property (@(posedge clk) disable iff (warm <= LATENCY)
        sort_out[BUS_W-1 -: ELEM_W] == last_ref);

endmodule

bind bitonic_sorter bsort_chk #(
    .LANES     (LANES),
    .ELEM_W    (ELEM_W),
    .DESCEND   (DESCEND),
    .SIGNED_CMP(SIGNED_CMP),
    .REG_EVERY (REG_EVERY)
) u_bsort_chk (
    .clk     (clk),
    .sort_in (sort_in),
    .sort_out(sort_out)
);

// File: tb/bitonic_sorter_test.sv
`timescale 1ns/1ps
module bitonic_sorter_test;

    localparam int A_N = 8,  A_W = 8, A_DESC = 0, A_SGN = 0, A_PR = 1;
    localparam int B_N = 16, B_W = 4, B_DESC = 1, B_SGN = 1, B_PR = 4;
    localparam int C_N = 4,  C_W = 6, C_DESC = 1, C_SGN = 0, C_PR = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [A_N*A_W-1:0] a_in = '0;
    logic [A_N*A_W-1:0] a_out;
    logic [B_N*B_W-1:0] b_in = '0;
    logic [B_N*B_W-1:0] b_out;
    logic [C_N*C_W-1:0] c_in = '0;
    logic [C_N*C_W-1:0] c_out;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    bitonic_sorter #(.LANES(A_N), .ELEM_W(A_W), .DESCEND(A_DESC), .SIGNED_CMP(A_SGN), .REG_EVERY(A_PR))
        uut (.clk(clk), .sort_in(a_in), .sort_out(a_out));
    bitonic_sorter #(.LANES(B_N), .ELEM_W(B_W), .DESCEND(B_DESC), .SIGNED_CMP(B_SGN), .REG_EVERY(B_PR))
        uut_sd (.clk(clk), .sort_in(b_in), .sort_out(b_out));
    bitonic_sorter #(.LANES(C_N), .ELEM_W(C_W), .DESCEND(C_DESC), .SIGNED_CMP(C_SGN), .REG_EVERY(C_PR))
        uut_cb (.clk(clk), .sort_in(c_in), .sort_out(c_out));

    // R6 R7: latency from the layer-count formula
    function automatic int exp_latency(input int n, input int pr);
        int lg = 0;
        int layers;
        while ((1 << lg) < n) lg++;
        layers = lg * (lg + 1) / 2;
        if (pr == 0 || pr > layers) return 0;
        return layers / pr;
    endfunction

    function automatic longint lane_val(input int mode, input int lane, input int step, input int w);
        longint mask = (longint'(1) << w) - 1;
        longint v;
        case (mode)
            0: v = longint'($urandom);
            1: v = step * 7 + 3;
            2: v = lane + step;
            3: v = 1000 - lane * 3 - step;
            4: case ((lane + step) % 4)
                   0: v = longint'(1) << (w - 1);
                   1: v = mask >> 1;
                   2: v = 0;
                   default: v = mask;
               endcase
            default: v = longint'($urandom % 3);
        endcase
        return v & mask;
    endfunction

    function automatic logic [127:0] make_vec(input int mode, input int step, input int n, input int w);
        logic [127:0] vec = '0;
        for (int lane = 0; lane < n; lane++)
            vec = vec | (128'(lane_val(mode, lane, step, w)) << (lane * w));
        return vec;
    endfunction

    // R5 lane layout, R1-style order by value, R3/R4 comparison kind
    function automatic logic [127:0] ref_sort(input logic [127:0] v, input int n, input int w,
                                              input int desc, input int sgn);
        longint vals [16];
        longint mask = (longint'(1) << w) - 1;
        longint t;
        logic [127:0] res = '0;
        for (int i = 0; i < n; i++) begin
            t = longint'(v >> (i * w)) & mask;
            if (sgn != 0 && t[w-1]) t = t - (longint'(1) << w);
            vals[i] = t;
        end
        for (int i = 1; i < n; i++) begin
            t = vals[i];
            for (int j = i - 1; j >= 0; j--) begin
                if (vals[j] > t) begin
                    vals[j+1] = vals[j];
                    vals[j] = t;
                end
            end
        end
        for (int i = 0; i < n; i++) begin
            t = (desc != 0) ? vals[n-1-i] : vals[i];
            res = res | (128'(t & mask) << (i * w));
        end
        return res;
    endfunction

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    initial begin
        int da, db, dc;
        logic [127:0] qa [$];
        logic [127:0] qb [$];
        logic [127:0] qc [$];
        da = exp_latency(A_N, A_PR);
        db = exp_latency(B_N, B_PR);
        dc = exp_latency(C_N, C_PR);
        if (da == 0) da = 1;
        if (db == 0) db = 1;
        if (dc == 0) dc = 1;
        for (int mode = 0; mode < 6; mode++) begin
            for (int step = 0; step < 40; step++) begin
                logic [127:0] va, vb, vc, pre_a, pre_b;
                @(negedge clk);
                if (qa.size() == da)
                    check($sformatf("R1 R3 R5 R6 R8 R9 asc/unsigned mode %0d", mode), 128'(a_out), qa.pop_front());
                if (qb.size() == db)
                    check($sformatf("R2 R4 R5 R6 R8 R9 desc/signed mode %0d", mode), 128'(b_out), qb.pop_front());
                if (qc.size() == dc)
                    check($sformatf("R2 R3 R7 R9 comb mode %0d", mode), 128'(c_out), qc.pop_front());
                pre_a = 128'(a_out);
                pre_b = 128'(b_out);
                va = make_vec(mode, step, A_N, A_W);
                vb = make_vec(mode, step + 11, B_N, B_W);
                vc = make_vec(mode, step + 5, C_N, C_W);
                a_in = va[A_N*A_W-1:0];
                b_in = vb[B_N*B_W-1:0];
                c_in = vc[C_N*C_W-1:0];
                qa.push_back(ref_sort(va, A_N, A_W, A_DESC, A_SGN));
                qb.push_back(ref_sort(vb, B_N, B_W, B_DESC, B_SGN));
                qc.push_back(ref_sort(vc, C_N, C_W, C_DESC, C_SGN));
                #1;
                // R6: registered outputs hold between edges
                check("R6 pipelined output held between edges", 128'(a_out), pre_a);
                check("R6 partly pipelined output held between edges", 128'(b_out), pre_b);
                // R7: register-free network answers in the same cycle
                check($sformatf("R7 same-cycle result mode %0d", mode), 128'(c_out),
                      ref_sort(vc, C_N, C_W, C_DESC, C_SGN));
            end
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule